// File: doc/BRIEF.md
# Delayed-branch next-PC sequencer

This block holds the two program-counter registers of a 32-bit processor whose control transfers take effect one instruction late. The block holds a current PC and a next PC. Each time an instruction retires, the current PC takes the old next PC, and the next PC moves forward by 4, or to a branch or jump destination. As a result, the instruction after any branch or jump always runs before control reaches the destination. This instruction is the delay slot.

The surrounding pipeline supplies the retiring instruction word, a one-cycle step strobe, and the values read from the two source registers the instruction names. The block decodes the conditional branches, the jumps and the register jump. It returns the updated PC pair. It also returns a request to write a return address into register 31, together with the value to write. Instruction fetch, the register file and data memory belong to the surrounding pipeline.

Top module: `npc_seq`

## Requirements
- R1: While rst_n is low, pc becomes START_ADDR and npc becomes START_ADDR+4, and link_we is 0.
- R2: With step low, pc and npc keep their values and link_we is 0, whatever the instruction word is.
- R3: On every clock edge with step high, pc takes the previous npc. For an instruction that is not a control transfer (for example opcode instr[31:26]=001000), npc becomes the previous npc plus 4.
- R4: Opcode 000100 branches when rs_val equals rt_val. Opcode 000101 branches when they differ. A taken branch sets npc to the old npc plus the sign-extended instr[15:0] shifted left by 2. A branch that is not taken adds 4.
- R5: Opcode 000110 branches when rs_val, read as signed, is zero or negative. Opcode 000111 branches when it is strictly positive.
- R6: Opcode 000001 selects on instr[20:16]: 00000 branches if rs_val is negative, 00001 branches if it is zero or positive, and 10000 and 10001 apply the same two tests. Any other code advances npc by 4.
- R7: For instr[20:16] of 10000 or 10001 under opcode 000001, link_we is high in the step cycle only if the branch is taken. In that case link_val is pc+8.
- R8: Opcode 000010 sets npc to the old npc bits [31:28] joined with instr[25:0] shifted left by 2.
- R9: Opcode 000011 jumps as in R8 and always raises link_we, with link_val equal to pc+8.
- R10: Opcode 000000 with instr[5:0]=001000 sets npc to rs_val.
- R11: A negative displacement moves npc backwards, with 32-bit wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction retires this cycle |
| instr | input | 32 | Retiring instruction word |
| rs_val | input | 32 | Value of the rs register |
| rt_val | input | 32 | Value of the rt register |
| pc | output | 32 | Current program counter |
| npc | output | 32 | Next program counter |
| link_we | output | 1 | Write request for register 31 |
| link_val | output | 32 | Return address to write |

## Verification
The link request and its value are combinational, so they are due in the same cycle as the step strobe. The bench reads them mid-cycle, while step is high and before the next rising edge. The pc and npc registers change at the rising edge that ends the step cycle. The bench samples them at the following falling edge, after dropping step, so every register result is read exactly one edge after its stimulus.

// File: rtl/npc_seq.sv
module npc_seq #(
  parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic [31:0] npc,
  output logic        link_we,
  output logic [31:0] link_val
);
  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_REGIMM  = 6'b000001;
  localparam logic [5:0] OP_J       = 6'b000010;
  localparam logic [5:0] OP_JAL     = 6'b000011;
  localparam logic [5:0] OP_BEQ     = 6'b000100;
  localparam logic [5:0] OP_BNE     = 6'b000101;
  localparam logic [5:0] OP_BLEZ    = 6'b000110;
  localparam logic [5:0] OP_BGTZ    = 6'b000111;
  localparam logic [5:0] FN_JR      = 6'b001000;

  logic [5:0]  opc, fn;
  logic [4:0]  sel;
  logic [31:0] disp, seq_tgt, br_tgt, jmp_tgt;
  logic        rs_neg, rs_zero, regimm_ok, taken;
  logic [31:0] npc_nx;

  assign opc     = instr[31:26];
  assign fn      = instr[5:0];
  assign sel     = instr[20:16];
  assign disp    = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign seq_tgt = npc + 32'd4;
  assign br_tgt  = npc + disp;
  assign jmp_tgt = {npc[31:28], instr[25:0], 2'b00};
  assign rs_neg  = rs_val[31];
  assign rs_zero = (rs_val == 32'd0);
  assign regimm_ok = (sel[3:1] == 3'b000);

  always_comb begin
    taken = 1'b0;
    case (opc)
      OP_BEQ:    taken = (rs_val == rt_val);
      OP_BNE:    taken = (rs_val != rt_val);
      OP_BLEZ:   taken = rs_neg | rs_zero;
      OP_BGTZ:   taken = ~rs_neg & ~rs_zero;
      OP_REGIMM: taken = regimm_ok & (sel[0] ? ~rs_neg : rs_neg);
      default:   taken = 1'b0;
    endcase
  end

  always_comb begin
    npc_nx = taken ? br_tgt : seq_tgt;
    if (opc == OP_J || opc == OP_JAL)
      npc_nx = jmp_tgt;
    else if (opc == OP_SPECIAL && fn == FN_JR)
      npc_nx = rs_val;
  end

  assign link_we  = step & ((opc == OP_JAL) |
                            ((opc == OP_REGIMM) & sel[4] & taken));
  assign link_val = pc + 32'd8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= START_ADDR;
      npc <= START_ADDR + 32'd4;
    end else if (step) begin
      pc  <= npc;
      npc <= npc_nx;
    end
  end
endmodule

// File: rtl/npc_seq_chk.sv
module npc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] pc,
  input logic [31:0] npc,
  input logic        link_we
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(pc) && $stable(npc))); // R2
  AST_IDLE_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> !link_we); // R2
  AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pc == $past(npc))); // R3
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && instr[31:26] == 6'b001000) |=> (npc == $past(npc) + 32'd4)); // R3
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (step && instr[31:26] == 6'b000010) |=> (npc[31:28] == pc[31:28])); // R8
  AST_JR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step && instr[31:26] == 6'b000000 && instr[5:0] == 6'b001000)
      |=> (npc == $past(rs_val))); // R10
endmodule

bind npc_seq npc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .instr(instr),
  .rs_val(rs_val), .pc(pc), .npc(npc), .link_we(link_we)
);

// File: tb/tb_npc_seq.sv
`timescale 1ns/1ps
module tb_npc_seq;
  localparam logic [31:0] START = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [31:0] instr = 32'd0;
  logic [31:0] rs_val = 32'd0;
  logic [31:0] rt_val = 32'd0;
  logic [31:0] pc, npc, link_val;
  logic        link_we;

  int total = 0;
  int bad = 0;
  logic [31:0] mpc, mnpc;

  always #2 clk = ~clk;

  npc_seq #(.START_ADDR(START)) dut (
    .clk(clk), .rst_n(rst_n), .step(step), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .npc(npc),
    .link_we(link_we), .link_val(link_val)
  );

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rt,
                                        input logic [15:0] imm);
    return {op, 5'd3, rt, imm};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_step(input string req, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp_npc, input logic exp_we);
    @(negedge clk);
    instr = ins; rs_val = a; rt_val = b; step = 1'b1;
    #1;
    chk(req, "link_we", {31'd0, link_we}, {31'd0, exp_we});
    if (exp_we) chk(req, "link_val", link_val, mpc + 32'd8);
    @(negedge clk);
    step = 1'b0;
    chk(req, "pc", pc, mnpc);
    chk(req, "npc", npc, exp_npc);
    mpc = mnpc;
    mnpc = exp_npc;
  endtask

  function automatic logic [31:0] br(input logic [15:0] imm);
    return mnpc + {{14{imm[15]}}, imm, 2'b00};
  endfunction

  task automatic t_reset;
    chk("R1", "pc", pc, START);
    chk("R1", "npc", npc, START + 32'd4);
    chk("R1", "link_we", {31'd0, link_we}, 32'd0);
    mpc = START; mnpc = START + 32'd4;
  endtask

  task automatic t_hold;
    @(negedge clk);
    instr = {6'b000011, 26'h0AB_CDEF}; step = 1'b0;
    #1 chk("R2", "link_we idle", {31'd0, link_we}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R2", "pc hold", pc, mpc);
    chk("R2", "npc hold", npc, mnpc);
  endtask

  task automatic t_seq;
    do_step("R3", itype(6'b001000, 5'd4, 16'h1234), 0, 0, mnpc + 4, 1'b0);
    do_step("R3", itype(6'b100011, 5'd4, 16'h0010), 0, 0, mnpc + 4, 1'b0);
  endtask

  task automatic t_eq_ne;
    do_step("R4", itype(6'b000100, 5'd5, 16'h0003), 32'h55, 32'h55, br(16'h0003), 1'b0);
    do_step("R4", itype(6'b000100, 5'd5, 16'h0003), 32'h55, 32'h56, mnpc + 4, 1'b0);
    do_step("R4", itype(6'b000101, 5'd5, 16'h0010), 32'h1, 32'h2, br(16'h0010), 1'b0);
    do_step("R4", itype(6'b000101, 5'd5, 16'h0010), 32'h7, 32'h7, mnpc + 4, 1'b0);
  endtask

  task automatic t_sign;
    do_step("R5", itype(6'b000110, 5'd0, 16'h0002), 32'h0, 0, br(16'h0002), 1'b0);
    do_step("R5", itype(6'b000110, 5'd0, 16'h0002), 32'hFFFF_FFFF, 0, br(16'h0002), 1'b0);
    do_step("R5", itype(6'b000110, 5'd0, 16'h0002), 32'h1, 0, mnpc + 4, 1'b0);
    do_step("R5", itype(6'b000111, 5'd0, 16'h0005), 32'h8000_0000, 0, mnpc + 4, 1'b0);
    do_step("R5", itype(6'b000111, 5'd0, 16'h0005), 32'h0, 0, mnpc + 4, 1'b0);
    do_step("R5", itype(6'b000111, 5'd0, 16'h0005), 32'h5, 0, br(16'h0005), 1'b0);
  endtask

  task automatic t_regimm;
    do_step("R6", itype(6'b000001, 5'b00000, 16'h0004), 32'h8000_0001, 0, br(16'h0004), 1'b0);
    do_step("R6", itype(6'b000001, 5'b00000, 16'h0004), 32'h0, 0, mnpc + 4, 1'b0);
    do_step("R6", itype(6'b000001, 5'b00001, 16'h0004), 32'h0, 0, br(16'h0004), 1'b0);
    do_step("R6", itype(6'b000001, 5'b00001, 16'h0004), 32'hF000_0000, 0, mnpc + 4, 1'b0);
    do_step("R6", itype(6'b000001, 5'b00010, 16'h0004), 32'hF000_0000, 0, mnpc + 4, 1'b0);
    do_step("R7", itype(6'b000001, 5'b10000, 16'h0006), 32'hFFFF_FFF0, 0, br(16'h0006), 1'b1);
    do_step("R7", itype(6'b000001, 5'b10000, 16'h0006), 32'h10, 0, mnpc + 4, 1'b0);
    do_step("R7", itype(6'b000001, 5'b10001, 16'h0006), 32'h10, 0, br(16'h0006), 1'b1);
    do_step("R7", itype(6'b000001, 5'b10001, 16'h0006), 32'h8000_0000, 0, mnpc + 4, 1'b0);
  endtask

  task automatic t_backward;
    do_step("R11", itype(6'b000100, 5'd1, 16'hFFFE), 32'h9, 32'h9, mnpc - 32'd8, 1'b0);
    do_step("R11", itype(6'b000101, 5'd1, 16'h8000), 32'h9, 32'h8, mnpc - 32'h0002_0000, 1'b0);
  endtask

  task automatic t_jumps;
    do_step("R10", {6'b000000, 5'd7, 15'd0, 6'b001000}, 32'h8000_0100, 0, 32'h8000_0100, 1'b0);
    do_step("R8", {6'b000010, 26'h0000_040}, 0, 0, {mnpc[31:28], 26'h0000_040, 2'b00}, 1'b0);
    do_step("R8", {6'b000010, 26'h3FF_FFFF}, 0, 0, {mnpc[31:28], 26'h3FF_FFFF, 2'b00}, 1'b0);
    do_step("R9", {6'b000011, 26'h012_3456}, 0, 0, {mnpc[31:28], 26'h012_3456, 2'b00}, 1'b1);
    do_step("R10", {6'b000000, 5'd31, 15'd0, 6'b001000}, 32'h0040_0200, 0, 32'h0040_0200, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_hold;
        t_seq;
        t_eq_ne;
        t_sign;
        t_regimm;
        t_backward;
        t_jumps;
        t_hold;
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule